// File: doc/BRIEF.md
# Clock Output Enable Gating Controller

This block sits between a set of clock sources and the output drivers of a clock generator. For each of four clock outputs, it decides whether the output follows its source clock or is held at a fixed parked level. Four conditions feed that decision:

- two active-low enable pins, either of which an output can be routed to;
- a per-output register enable;
- per-PLL loss-of-lock flags, each of which can be set to take part or not;
- a crystal-loss alarm, which by default turns every output off.

All of this configuration arrives as plain input ports.

The asynchronous inputs (pins, lock flags and alarm) are resynchronized to the control clock. A per-output gate then applies the decision. In synchronous mode a gate changes state only while its source sits at the parked level, so no phase is ever shortened, whether the output is being switched off or on. In asynchronous mode the gate follows the decision at the next control edge, whatever the source is doing. The parked level is chosen per output.

Top module: `clk_out_gate`

## Requirements
- R1: While reset is asserted, every output is held at its configured parked level.
- R2: Each output has one pin-map bit: 0 routes it to `oe_pin_n[0]`, 1 routes it to `oe_pin_n[1]`. An output whose routed pin is low may be driven. An output whose routed pin is high is parked.
- R3: With every pin-map bit at 0, the level of `oe_pin_n[1]` has no effect on any output.
- R4: A register enable bit of 0 parks its output even while the routed pin enables it. A bit of 1 leaves the decision to the pin and the fault conditions.
- R5: Outputs 0 and 1 belong to PLL A (`pll_unlock[0]`) and outputs 2 and 3 belong to PLL B (`pll_unlock[1]`). When a PLL's `cfg_lol_dis` bit is 1 and that PLL reports unlock, its outputs are parked. When the bit is 0, the outputs keep running through unlock.
- R6: While `xtal_loss` is high, all outputs are parked if `cfg_xtal_keep` is 0. If `cfg_xtal_keep` is 1, the alarm has no effect.
- R7: A parked output sits at logic 1 when its `cfg_park_hi` bit is 1, and at logic 0 when the bit is 0.
- R8: In synchronous mode (`cfg_async` bit 0), a disable takes effect only at a control edge where the source is at the parked level. A phase already in progress completes at full length.
- R9: In synchronous mode, a re-enable also waits for the source to be at the parked level, so the first driven phase has full width.
- R10: In asynchronous mode (`cfg_async` bit 1), the gate adopts the new decision at the control edge after the two-flop synchronizer. An output can therefore be cut or started in mid-phase, three control edges after an input change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Control clock |
| rst_n | input | 1 | Active-low reset |
| src_clk | input | 4 | Source clock for each output |
| oe_pin_n | input | 2 | Active-low enable pins, asynchronous |
| pll_unlock | input | 2 | Loss-of-lock flags, bit 0 PLL A, bit 1 PLL B |
| xtal_loss | input | 1 | Crystal-loss alarm, asynchronous |
| cfg_pin_map | input | 4 | Per-output pin selection |
| cfg_reg_en | input | 4 | Per-output register enable |
| cfg_lol_dis | input | 2 | Per-PLL: park outputs on unlock |
| cfg_xtal_keep | input | 1 | 1 keeps outputs running during crystal loss |
| cfg_park_hi | input | 4 | Per-output parked level |
| cfg_async | input | 4 | Per-output gating mode, 1 asynchronous |
| out_clk | output | 4 | Gated output clocks |

## Verification
The gate assertions assume three things about each source clock. It is synchronous to the control clock, it changes away from the rising control edge, and each of its phases lasts at least two control cycles, so that a rising-edge sample is a true picture of its level. The bench toggles the sources only on falling control edges, with half-periods of two to five cycles. It holds configuration steady while a phase boundary is being observed. It changes the enable pins only in the middle of the low control phase, just after a source has turned away from the parked level, which is the moment where a runt would appear if the gating were wrong.

// File: rtl/clk_out_gate_pkg.sv
package clk_out_gate_pkg;

    typedef enum logic {
        GATE_SYNC  = 1'b0,
        GATE_ASYNC = 1'b1
    } gate_mode_e;

    typedef struct packed {
        logic en;
    } gate_state_t;

endpackage

// File: rtl/ogc_sync.sv
module ogc_sync #(
    parameter int              W       = 4,
    parameter int              STAGES  = 2,
    parameter logic [W-1:0]    RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);

    typedef struct packed {
        logic [STAGES-1:0][W-1:0] chain;
    } sync_state_t;

    sync_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        st_d.chain[0] = din;
        for (int s = 1; s < STAGES; s++) begin
            st_d.chain[s] = st_q.chain[s-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.chain <= {STAGES{RST_VAL}};
        end else begin
            st_q <= st_d;
        end
    end

    assign dout = st_q.chain[STAGES-1];

endmodule

// File: rtl/ogc_enable_logic.sv
module ogc_enable_logic #(
    parameter int N_OUT = 4,
    parameter int N_PLL = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [1:0]       pin_n_s,
    input  logic [N_PLL-1:0] unlock_s,
    input  logic             xtal_s,
    input  logic [N_OUT-1:0] cfg_pin_map,
    input  logic [N_OUT-1:0] cfg_reg_en,
    input  logic [N_PLL-1:0] cfg_lol_dis,
    input  logic             cfg_xtal_keep,
    output logic [N_OUT-1:0] want_en
);

    localparam int OUT_PER_PLL = N_OUT / N_PLL;

    logic xtal_block;
    assign xtal_block = xtal_s && !cfg_xtal_keep;

    for (genvar g = 0; g < N_OUT; g++) begin : g_out
        localparam int P = g / OUT_PER_PLL;
        logic pin_on;
        logic lol_block;

        assign pin_on    = cfg_pin_map[g] ? !pin_n_s[1] : !pin_n_s[0];
        assign lol_block = cfg_lol_dis[P] && unlock_s[P];
        assign want_en[g] = pin_on && cfg_reg_en[g] && !lol_block && !xtal_block;

        AST_LOL_PARKS: assert property (@(posedge clk) disable iff (!rst_n)
            (cfg_lol_dis[P] && unlock_s[P]) |-> !want_en[g]); // R5
    end

    AST_REG_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        (want_en & ~cfg_reg_en) == '0); // R4

    AST_XTAL_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        (xtal_s && !cfg_xtal_keep) |-> (want_en == '0)); // R6

endmodule

// File: rtl/ogc_gate_cell.sv
module ogc_gate_cell
    import clk_out_gate_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       src_clk,
    input  logic       want_en,
    input  gate_mode_e mode,
    input  logic       park_hi,
    output logic       out_clk
);

    gate_state_t st_d, st_q;
    logic        at_park;

    assign at_park = (src_clk == park_hi);

    always_comb begin
        st_d = st_q;
        if (mode == GATE_ASYNC) begin
            st_d.en = want_en;
        end else if (at_park) begin
            st_d.en = want_en;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.en <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign out_clk = st_q.en ? src_clk : park_hi;

    AST_SYNC_AT_PARK: assert property (@(posedge clk) disable iff (!rst_n)
        (!$stable(st_q.en) && ($past(mode) == GATE_SYNC))
            |-> ($past(src_clk) == $past(park_hi))); // R8

    AST_ASYNC_FOLLOW: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(mode) == GATE_ASYNC) |-> (st_q.en == $past(want_en))); // R10

endmodule

// File: rtl/clk_out_gate.sv
module clk_out_gate
    import clk_out_gate_pkg::*;
#(
    parameter int N_OUT       = 4,
    parameter int N_PLL       = 2,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_OUT-1:0] src_clk,
    input  logic [1:0]       oe_pin_n,
    input  logic [N_PLL-1:0] pll_unlock,
    input  logic             xtal_loss,
    input  logic [N_OUT-1:0] cfg_pin_map,
    input  logic [N_OUT-1:0] cfg_reg_en,
    input  logic [N_PLL-1:0] cfg_lol_dis,
    input  logic             cfg_xtal_keep,
    input  logic [N_OUT-1:0] cfg_park_hi,
    input  logic [N_OUT-1:0] cfg_async,
    output logic [N_OUT-1:0] out_clk
);

    localparam int          SW      = 2 + N_PLL + 1;
    localparam logic [SW-1:0] SYNC_RST = {1'b0, {N_PLL{1'b0}}, 2'b11};

    logic [SW-1:0]    raw_async;
    logic [SW-1:0]    synced;
    logic [1:0]       pin_n_s;
    logic [N_PLL-1:0] unlock_s;
    logic             xtal_s;
    logic [N_OUT-1:0] want_en;

    assign raw_async = {xtal_loss, pll_unlock, oe_pin_n};

    ogc_sync #(
        .W       (SW),
        .STAGES  (SYNC_STAGES),
        .RST_VAL (SYNC_RST)
    ) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .din   (raw_async),
        .dout  (synced)
    );

    assign pin_n_s  = synced[1:0];
    assign unlock_s = synced[2 +: N_PLL];
    assign xtal_s   = synced[SW-1];

    ogc_enable_logic #(
        .N_OUT (N_OUT),
        .N_PLL (N_PLL)
    ) u_enable (
        .clk           (clk),
        .rst_n         (rst_n),
        .pin_n_s       (pin_n_s),
        .unlock_s      (unlock_s),
        .xtal_s        (xtal_s),
        .cfg_pin_map   (cfg_pin_map),
        .cfg_reg_en    (cfg_reg_en),
        .cfg_lol_dis   (cfg_lol_dis),
        .cfg_xtal_keep (cfg_xtal_keep),
        .want_en       (want_en)
    );

    for (genvar g = 0; g < N_OUT; g++) begin : g_gate
        ogc_gate_cell u_gate (
            .clk     (clk),
            .rst_n   (rst_n),
            .src_clk (src_clk[g]),
            .want_en (want_en[g]),
            .mode    (gate_mode_e'(cfg_async[g])),
            .park_hi (cfg_park_hi[g]),
            .out_clk (out_clk[g])
        );
    end

    always_comb begin
        if (!rst_n) begin
            AST_RESET_PARKED: assert (out_clk == cfg_park_hi); // R1
        end
    end

endmodule

// File: tb/clk_out_gate_tb.sv
`timescale 1ns/1ps
module clk_out_gate_tb;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] src_clk = 4'b0000;
    logic [1:0] oe_pin_n = 2'b11;
    logic [1:0] pll_unlock = 2'b00;
    logic       xtal_loss = 1'b0;
    logic [3:0] cfg_pin_map = 4'b0000;
    logic [3:0] cfg_reg_en = 4'b1111;
    logic [1:0] cfg_lol_dis = 2'b00;
    logic       cfg_xtal_keep = 1'b0;
    logic [3:0] cfg_park_hi = 4'b0000;
    logic [3:0] cfg_async = 4'b0000;
    logic [3:0] out_clk;

    int n_tests = 0;
    int n_fail  = 0;

    always #5 clk = ~clk;

    clk_out_gate u_dut (
        .clk           (clk),
        .rst_n         (rst_n),
        .src_clk       (src_clk),
        .oe_pin_n      (oe_pin_n),
        .pll_unlock    (pll_unlock),
        .xtal_loss     (xtal_loss),
        .cfg_pin_map   (cfg_pin_map),
        .cfg_reg_en    (cfg_reg_en),
        .cfg_lol_dis   (cfg_lol_dis),
        .cfg_xtal_keep (cfg_xtal_keep),
        .cfg_park_hi   (cfg_park_hi),
        .cfg_async     (cfg_async),
        .out_clk       (out_clk)
    );

    // source clocks: half-periods of 2,3,4,5 control cycles, toggled on falling edges
    localparam int HALF [4] = '{2, 3, 4, 5};
    int cnt [4] = '{0, 0, 0, 0};

    always @(negedge clk) begin
        for (int i = 0; i < 4; i++) begin
            if (cnt[i] == HALF[i] - 1) begin
                cnt[i]     <= 0;
                src_clk[i] <= ~src_clk[i];
            end else begin
                cnt[i] <= cnt[i] + 1;
            end
        end
    end

    // {pin_n[2], unlock[2], xtal, keep, lol_dis[2], map[4], reg_en[4], park[4], async[4], expected_enable[4]}
    localparam int NV = 13;
    localparam logic [27:0] VECS [NV] = '{
        {2'b10, 2'b00, 1'b0, 1'b0, 2'b00, 4'b0000, 4'b1111, 4'b0000, 4'b0000, 4'b1111},
        {2'b11, 2'b00, 1'b0, 1'b0, 2'b00, 4'b0000, 4'b1111, 4'b0000, 4'b0000, 4'b0000},
        {2'b01, 2'b00, 1'b0, 1'b0, 2'b00, 4'b0000, 4'b1111, 4'b0000, 4'b0000, 4'b0000},
        {2'b01, 2'b00, 1'b0, 1'b0, 2'b00, 4'b1100, 4'b1111, 4'b0000, 4'b0000, 4'b1100},
        {2'b10, 2'b00, 1'b0, 1'b0, 2'b00, 4'b1100, 4'b1111, 4'b0000, 4'b0000, 4'b0011},
        {2'b10, 2'b00, 1'b0, 1'b0, 2'b00, 4'b0000, 4'b1010, 4'b0101, 4'b0000, 4'b1010},
        {2'b10, 2'b01, 1'b0, 1'b0, 2'b00, 4'b0000, 4'b1111, 4'b0000, 4'b0000, 4'b1111},
        {2'b10, 2'b01, 1'b0, 1'b0, 2'b01, 4'b0000, 4'b1111, 4'b0000, 4'b0000, 4'b1100},
        {2'b10, 2'b10, 1'b0, 1'b0, 2'b11, 4'b0000, 4'b1111, 4'b0000, 4'b0000, 4'b0011},
        {2'b10, 2'b00, 1'b1, 1'b0, 2'b00, 4'b0000, 4'b1111, 4'b1111, 4'b0000, 4'b0000},
        {2'b10, 2'b00, 1'b1, 1'b1, 2'b00, 4'b0000, 4'b1111, 4'b0000, 4'b0000, 4'b1111},
        {2'b10, 2'b00, 1'b0, 1'b0, 2'b00, 4'b0000, 4'b1111, 4'b0000, 4'b1111, 4'b1111},
        {2'b11, 2'b00, 1'b0, 1'b0, 2'b00, 4'b0000, 4'b1111, 4'b0110, 4'b1111, 4'b0000}
    };

    function automatic string vec_tag(int k);
        case (k)
            0, 1, 3, 4: return "R2";
            2:          return "R3";
            5:          return "R4";
            6, 7, 8:    return "R5";
            9, 10:      return "R6";
            11:         return "R10";
            default:    return "R7";
        endcase
    endfunction

    task automatic check(input bit ok, input string req, input logic [3:0] act, input logic [3:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %b expected %b at %0t", req, act, exp, $time);
        end
    endtask

    task automatic apply_vec(input logic [27:0] v);
        @(negedge clk);
        #1;
        oe_pin_n      = v[27:26];
        pll_unlock    = v[25:24];
        xtal_loss     = v[23];
        cfg_xtal_keep = v[22];
        cfg_lol_dis   = v[21:20];
        cfg_pin_map   = v[19:16];
        cfg_reg_en    = v[15:12];
        cfg_park_hi   = v[11:8];
        cfg_async     = v[7:4];
    endtask

    task automatic wait_rise3();
        do begin
            @(negedge clk);
            #1;
        end while (!(src_clk[3] == 1'b1 && cnt[3] == 0));
    endtask

    task automatic wait_cycles_sample(input int n);
        repeat (n) @(posedge clk);
        #2;
    endtask

    initial begin
        #1000000;
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        // R1: parked level during reset
        cfg_park_hi = 4'b1010;
        wait_cycles_sample(4);
        check(out_clk == 4'b1010, "R1", out_clk, 4'b1010);
        @(negedge clk);
        rst_n = 1'b1;

        // table walk
        for (int k = 0; k < NV; k++) begin
            logic [3:0] bad;
            logic [3:0] last_act;
            logic [3:0] last_exp;
            logic [3:0] exp_en;
            bad = '0;
            last_act = '0;
            last_exp = '0;
            apply_vec(VECS[k]);
            exp_en = VECS[k][3:0];
            repeat (30) @(posedge clk);
            for (int c = 0; c < 20; c++) begin
                wait_cycles_sample(1);
                for (int i = 0; i < 4; i++) begin
                    logic e;
                    e = exp_en[i] ? src_clk[i] : cfg_park_hi[i];
                    if (out_clk[i] !== e) begin
                        bad[i] = 1'b1;
                        last_act[i] = out_clk[i];
                        last_exp[i] = e;
                    end
                end
            end
            for (int i = 0; i < 4; i++) begin
                check(!bad[i], vec_tag(k), last_act, last_exp);
            end
        end

        // directed: synchronous disable and enable on output 3
        apply_vec({2'b10, 2'b00, 1'b0, 1'b0, 2'b00, 4'b0000, 4'b1111, 4'b0000, 4'b0000, 4'b1111});
        repeat (30) @(posedge clk);
        wait_rise3();
        oe_pin_n = 2'b11;
        wait_cycles_sample(4);
        check(out_clk[3] == 1'b1 && src_clk[3] == 1'b1, "R8 high phase completes", {3'b0, out_clk[3]}, 4'b0001);
        wait_cycles_sample(20);
        check(out_clk[3] == 1'b0, "R8 parked after phase", {3'b0, out_clk[3]}, 4'b0000);
        wait_rise3();
        oe_pin_n = 2'b10;
        wait_cycles_sample(4);
        check(out_clk[3] == 1'b0 && src_clk[3] == 1'b1, "R9 no partial first phase", {3'b0, out_clk[3]}, 4'b0000);

        // directed: asynchronous disable and enable on output 3
        @(negedge clk);
        #1;
        cfg_async = 4'b1000;
        repeat (30) @(posedge clk);
        wait_rise3();
        oe_pin_n = 2'b11;
        wait_cycles_sample(4);
        check(out_clk[3] == 1'b0 && src_clk[3] == 1'b1, "R10 cut mid-phase", {3'b0, out_clk[3]}, 4'b0000);
        wait_rise3();
        oe_pin_n = 2'b10;
        wait_cycles_sample(4);
        check(out_clk[3] == 1'b1 && src_clk[3] == 1'b1, "R10 start mid-phase", {3'b0, out_clk[3]}, 4'b0001);

        // directed: synchronous disable with high parked level on output 3
        @(negedge clk);
        #1;
        cfg_async = 4'b0000;
        cfg_park_hi = 4'b1000;
        repeat (30) @(posedge clk);
        wait_rise3();
        oe_pin_n = 2'b11;
        wait_cycles_sample(20);
        check(out_clk[3] == 1'b1, "R7 parked high", {3'b0, out_clk[3]}, 4'b0001);

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule